// File: doc/BRIEF.md
# Pulse-Width Byte Modulator

This block turns one byte into a pulse-width coded drive signal for a low-frequency reader antenna. Each bit becomes a symbol of constant length. The symbol opens with a quiet interval, where the output is low and the antenna is not modulated. It closes with a modulated interval, where the output is high. The bit value sets where the symbol switches from the first part to the second: a one splits the symbol evenly, and a zero keeps the quiet part short. The bits leave least-significant first.

All timing is counted in microsecond ticks from an external strobe, so the system clock can run at any rate. A controller presents a byte and pulses `start`. The block then holds `busy` for the length of the transmission and pulses `done` when the last symbol has finished. Between bytes the output rests high.

Top module: `pw_byte_modulator`

## Requirements
- R1: Once reset has been sampled low at a clock edge, `busy` and `done` are 0 and `mod_out` is 1. Reset is synchronous and active low.
- R2: A `start` sampled high while `busy` is 0 is accepted. In the next cycle `busy` is 1 and `mod_out` is 0.
- R3: Exactly NBITS symbols (8 by default) are sent per byte. Symbol k carries bit k of the byte latched at acceptance, starting with k = 0.
- R4: A symbol for a one bit holds `mod_out` low for LO_ONE ticks (default 1000), then high for HI_ONE ticks (default 1000).
- R5: A symbol for a zero bit holds `mod_out` low for LO_ZERO ticks (default 300), then high for HI_ZERO ticks (default 1700).
- R6: Every symbol starts with its low part and ends with its high part. With the default values every symbol lasts 2000 ticks.
- R7: `start` and `data_in` are ignored while `busy` is 1. The transmitted waveform depends only on the byte captured at acceptance.
- R8: In the cycle after the tick that ends the last high part, `done` is 1 for exactly one cycle, `busy` is 0 and `mod_out` stays 1. A new `start` may be accepted in that cycle.
- R9: Durations are counted only on cycles where `tick_us` is 1. A cycle without a tick changes neither `mod_out` nor `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| start | input | 1 | Request to send `data_in` |
| data_in | input | NBITS | Byte to transmit, captured on an accepted start |
| busy | output | 1 | High while symbols are being sent |
| done | output | 1 | One-cycle pulse after the final symbol |
| mod_out | output | 1 | Modulation drive: 0 quiet, 1 modulating |

## Verification
The model in the bench predicts `mod_out` for every cycle after acceptance. It does this by counting the ticks consumed in the cycles before the current one. The tick in the accepting cycle does not count, because the counter is loaded in that cycle. The first symbol's low level is therefore due one cycle after the accepting edge. Each phase change is due one cycle after the tick that uses up its count, and `done` is due in the cycle after the final tick, with `done` clearing one cycle later. The bench changes inputs at falling edges and samples every output at the falling edge of each cycle. This keeps stalls, mid-transmission disturbances and back-to-back starts aligned with that count.

// File: rtl/pbm_pkg.sv
// Shared types for the pulse-width byte modulator.
package pbm_pkg;
    // Phase of the transmitter: idle, quiet part or modulated part of a symbol.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } pbm_phase_e;
endpackage

// File: rtl/pbm_timer.sv
// Phase duration counter.
// Counts down once per tick. It reports expiry on the tick that consumes the last count.
// Assumes: every loaded value is at least 1, and a load takes precedence over a decrement.
module pbm_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new duration or count down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (load)                   cnt_q <= load_val;
        else if (tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    // The phase ends on the tick that finds one count remaining.
    assign expire = tick && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pbm_shift.sv
// Byte holder and bit sequencer.
// Captures the byte and presents the current and next bit, least-significant first.
// Assumes: NBITS >= 2.
module pbm_shift #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [NBITS-1:0] data,
    input  logic             advance,
    output logic             cur_bit,
    output logic             nxt_bit,
    output logic             last_bit
);
    localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1;

    logic [NBITS-1:0] sh_q;
    logic [IDX_W-1:0] idx_q;

    // Hold the byte and step to the next bit after each symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (capture) begin
            sh_q  <= data;
            idx_q <= '0;
        end else if (advance) begin
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign cur_bit  = sh_q[0];
    assign nxt_bit  = sh_q[1];
    assign last_bit = (idx_q == IDX_W'(NBITS - 1));
endmodule

// File: rtl/pbm_ctrl.sv
// Symbol sequencer.
// Moves idle -> low -> high -> (low ... | idle) and selects each phase's duration from the bit value.
// Assumes: the timer expires only on ticks, and all durations are at least 1.
module pbm_ctrl
    import pbm_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int LO_ONE   = 1000,
    parameter int HI_ONE   = 1000,
    parameter int LO_ZERO  = 300,
    parameter int HI_ZERO  = 1700
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             first_bit,
    input  logic             cur_bit,
    input  logic             nxt_bit,
    input  logic             last_bit,
    input  logic             expire,
    output logic             capture,
    output logic             advance,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             done,
    output logic             mod_out
);
    localparam logic [CNT_W-1:0] LO1 = CNT_W'(LO_ONE);
    localparam logic [CNT_W-1:0] HI1 = CNT_W'(HI_ONE);
    localparam logic [CNT_W-1:0] LO0 = CNT_W'(LO_ZERO);
    localparam logic [CNT_W-1:0] HI0 = CNT_W'(HI_ZERO);

    pbm_phase_e state_q, state_n;
    logic       done_q, done_n;

    // Next-state, duration select and sequencing strobes.
    always_comb begin
        state_n  = state_q;
        done_n   = 1'b0;
        capture  = 1'b0;
        advance  = 1'b0;
        load     = 1'b0;
        load_val = '0;
        unique case (state_q)
            PH_IDLE: if (start) begin
                capture  = 1'b1;
                load     = 1'b1;
                load_val = first_bit ? LO1 : LO0;
                state_n  = PH_LOW;
            end
            PH_LOW: if (expire) begin
                load     = 1'b1;
                load_val = cur_bit ? HI1 : HI0;
                state_n  = PH_HIGH;
            end
            PH_HIGH: if (expire) begin
                if (last_bit) begin
                    state_n = PH_IDLE;
                    done_n  = 1'b1;
                end else begin
                    advance  = 1'b1;
                    load     = 1'b1;
                    load_val = nxt_bit ? LO1 : LO0;
                    state_n  = PH_LOW;
                end
            end
            default: state_n = PH_IDLE;
        endcase
    end

    // State and completion pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            done_q  <= done_n;
        end
    end

    assign busy    = (state_q != PH_IDLE);
    assign mod_out = (state_q != PH_LOW);
    assign done    = done_q;
endmodule

// File: rtl/pw_byte_modulator.sv
// Pulse-width byte modulator, top level.
// Sends one byte as NBITS constant-length symbols, LSB first, each timed in tick_us units.
// Assumes: tick_us is a single-cycle strobe and every duration parameter is at least 1.
module pw_byte_modulator #(
    parameter int NBITS   = 8,
    parameter int CNT_W   = 16,
    parameter int LO_ONE  = 1000,
    parameter int HI_ONE  = 1000,
    parameter int LO_ZERO = 300,
    parameter int HI_ZERO = 1700
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_us,
    input  logic             start,
    input  logic [NBITS-1:0] data_in,
    output logic             busy,
    output logic             done,
    output logic             mod_out
);
    logic             capture, advance, load, expire;
    logic             cur_bit, nxt_bit, last_bit;
    logic [CNT_W-1:0] load_val;

    pbm_shift #(.NBITS(NBITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .data     (data_in),
        .advance  (advance),
        .cur_bit  (cur_bit),
        .nxt_bit  (nxt_bit),
        .last_bit (last_bit)
    );

    pbm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .tick     (tick_us),
        .expire   (expire)
    );

    pbm_ctrl #(
        .CNT_W   (CNT_W),
        .LO_ONE  (LO_ONE),
        .HI_ONE  (HI_ONE),
        .LO_ZERO (LO_ZERO),
        .HI_ZERO (HI_ZERO)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .first_bit (data_in[0]),
        .cur_bit   (cur_bit),
        .nxt_bit   (nxt_bit),
        .last_bit  (last_bit),
        .expire    (expire),
        .capture   (capture),
        .advance   (advance),
        .load      (load),
        .load_val  (load_val),
        .busy      (busy),
        .done      (done),
        .mod_out   (mod_out)
    );
endmodule

// File: rtl/pbm_checker.sv
// Port-level properties for the pulse-width byte modulator, attached by bind.
module pbm_checker (
    input logic clk,
    input logic rst_n,
    input logic tick_us,
    input logic start,
    input logic busy,
    input logic done,
    input logic mod_out
);
    // R2: an accepted start opens the low part of the first symbol.
    a_r2_accept_goes_low: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !mod_out));

    // R8: the output rests high whenever no byte is in flight.
    a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> mod_out);

    // R8: done marks the end of a transmission and lasts one cycle.
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: without a tick nothing advances.
    a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick_us) |=> (busy && $stable(mod_out)));
endmodule

bind pw_byte_modulator pbm_checker u_pbm_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_us (tick_us),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .mod_out (mod_out)
);

// File: tb/pw_byte_modulator_bench.sv
module pw_byte_modulator_bench;
    localparam int LO1 = 5, HI1 = 5, LO0 = 2, HI0 = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b1;
    logic       start = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       busy, done, mod_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pw_byte_modulator #(
        .NBITS(8), .CNT_W(16),
        .LO_ONE(LO1), .HI_ONE(HI1), .LO_ZERO(LO0), .HI_ZERO(HI0)
    ) u_pw_byte_modulator (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .start(start),
        .data_in(data_in), .busy(busy), .done(done), .mod_out(mod_out)
    );

    // Vector: {byte, stall position, stall length, disturb flag}
    localparam logic [15:0] VEC [8] = '{
        {8'hA5, 4'd0, 3'd0, 1'b0},
        {8'h00, 4'd0, 3'd0, 1'b0},
        {8'hFF, 4'd0, 3'd0, 1'b0},
        {8'h01, 4'd0, 3'd0, 1'b0},
        {8'h80, 4'd0, 3'd0, 1'b1},
        {8'h3C, 4'd7, 3'd5, 1'b0},
        {8'h96, 4'd2, 3'd3, 1'b1},
        {8'h5A, 4'd1, 3'd7, 1'b0}
    };

    function automatic int total_ticks(input logic [7:0] b);
        int t = 0;
        for (int i = 0; i < 8; i++) t += b[i] ? (LO1 + HI1) : (LO0 + HI0);
        return t;
    endfunction

    // Expected output level after n ticks consumed (R3 to R6).
    function automatic logic level_at(input logic [7:0] b, input int n);
        int r = n;
        for (int i = 0; i < 8; i++) begin
            int lo = b[i] ? LO1 : LO0;
            int hi = b[i] ? HI1 : HI0;
            if (r < lo) return 1'b0;
            r -= lo;
            if (r < hi) return 1'b1;
            r -= hi;
        end
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Send one byte from an idle negedge; returns at the negedge of the done cycle.
    task automatic run_byte(input logic [7:0] b, input int st_at, input int st_len,
                            input bit disturb);
        int  n = 0;
        int  c = 0;
        int  tot = total_ticks(b);
        bit  wave_ok = 1'b1;
        bit  busy_ok = 1'b1;
        int  bad_act = 0, bad_exp = 0;
        data_in = b;
        start   = 1'b1;
        tick_us = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        c = 1;
        while (n < tot) begin
            if (mod_out !== level_at(b, n) && wave_ok) begin
                wave_ok = 1'b0;
                bad_act = mod_out;
                bad_exp = level_at(b, n);
            end
            if (busy !== 1'b1 || done !== 1'b0) busy_ok = 1'b0;
            // R7: disturbing start/data while busy
            if (disturb && c == 3) begin
                start   = 1'b1;
                data_in = ~b;
            end else begin
                start   = 1'b0;
                data_in = b;
            end
            // R9: stalled ticks
            tick_us = !(st_len != 0 && c >= st_at && c < st_at + st_len);
            n += tick_us ? 1 : 0;
            c++;
            @(negedge clk);
        end
        start   = 1'b0;
        tick_us = 1'b1;
        check(wave_ok, "R3/R4/R5/R6/R7/R9 waveform", bad_act, bad_exp);
        check(busy_ok, "R2/R7 busy held during byte", 0, 1);
        check(done === 1'b1 && busy === 1'b0 && mod_out === 1'b1,
              "R8 done cycle", {done, busy, mod_out}, 3'b101);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        check(busy === 1'b0 && done === 1'b0 && mod_out === 1'b1,
              "R1 reset state", {busy, done, mod_out}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk
        for (int v = 0; v < 8; v++) begin
            run_byte(VEC[v][15:8], int'(VEC[v][7:4]), int'(VEC[v][3:1]), VEC[v][0]);
            @(negedge clk);
            check(done === 1'b0 && mod_out === 1'b1, "R8 done single pulse, idle high",
                  {done, mod_out}, 2'b01);
        end

        // R8: back-to-back, start accepted in done cycle
        run_byte(8'hC3, 0, 0, 1'b0);
        run_byte(8'h18, 0, 0, 1'b0);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R8 idle after back-to-back",
              {done, busy}, 2'b00);

        // R2: accept timing, and R1: synchronous reset mid-byte
        data_in = 8'hFF;
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1 && mod_out === 1'b0, "R2 accept one cycle later",
              {busy, mod_out}, 2'b10);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        check(busy === 1'b1, "R1 reset is synchronous (no effect before edge)", busy, 1);
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && mod_out === 1'b1,
              "R1 reset mid-byte", {busy, done, mod_out}, 3'b001);
        // R7/R1: start during reset ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0, "R1 start ignored in reset", busy, 0);

        // R9: no ticks at all after start keeps low phase
        tick_us = 1'b0;
        data_in = 8'h00;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        check(busy === 1'b1 && mod_out === 1'b0, "R9 no tick no progress",
              {busy, mod_out}, 2'b10);
        tick_us = 1'b1;
        repeat (100) @(negedge clk);
        check(busy === 1'b0 && mod_out === 1'b1, "R3 byte completes after ticks resume",
              {busy, mod_out}, 2'b01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule